// File: doc/BRIEF.md
# Dual Timebase Prescaler

This block keeps two free-running timebase counters. Each one advances through its own programmable divider, and both are set up through one 16-bit configuration register. Timebase A counts the system clock. The clock first passes a fixed pre-divider of 32 or 4, then a programmable divider of 1, 2, 4 or 8. Timebase B takes one of two sources. It can count edges on an external input pin, or it can count an internal divide-by-8 clock that passes only while the pin is high. Either source then goes through B's own programmable divider.

The configuration register is written and read through a plain synchronous port. The write takes effect on the clock edge where the write enable is high. The read value is always present on the read output. A stop bit freezes both counters at their current values. A read-only flag reports that the stop has taken hold. Some setup fields accept only the first write after reset. For the two divider fields, a stored override bit lifts that restriction.

Top module: `tbase_pair`

## Requirements
- R1: After reset the register reads 0x0400: the compatibility bit (bit 10) is 1 and every other bit is 0. Both counters read 0.
- R2: Timebase A steps by exactly one every P running cycles, where P = pre × 2^code. Code is bits 2:1 (00 = /1, 01 = /2, 10 = /4, 11 = /8). Counting from the edge that clears the stop bit, the count after k edges is floor(k/P) above the held value.
- R3: Bit 9 selects the pre-divider of timebase A. A 0 selects 32 and a 1 selects 4.
- R4: While bit 0 (stop) is 1, neither counter changes. When bit 0 is cleared, both counters resume from their held values with the divider phase restarted.
- R5: Bit 7 reads the value bit 0 had one clock earlier. Writing bit 7 has no effect.
- R6: The divider fields (A in bits 2:1, B in bits 4:3) take the first write after reset. Later writes leave them unchanged while the stored override bit (bit 8) is 0.
- R7: While the stored override bit 8 is 1, writes update both divider fields.
- R8: Bit 5 (emulation) and bit 10 (compatibility) take only the first write after reset. No override applies to them.
- R9: With bit 6 = 0, timebase B counts edges of the synchronised pin through divider B (bits 4:3). It counts rising edges when bit 11 = 0 and both edges when bit 11 = 1.
- R10: With bit 6 = 1, timebase B counts one tick every 8 running cycles while the pin is high, through divider B. It counts nothing while the pin is low.
- R11: Both counters wrap from all ones to 0.
- R12: Bits 15:12 always read 0. Bits 0, 6, 8, 9 and 11 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback including the stop flag |
| ext_pin | input | 1 | Asynchronous external pin for timebase B |
| tb_a | output | CNT_W | Timebase A count |
| tb_b | output | CNT_W | Timebase B count |

## Verification
A wrong divider phase or pre-divider choice shows on tb_a as a wrong count within one period P, at most 256 cycles. The bench therefore measures exact counts after long runs across every divider and pre-divider setting. A sticky write flag or override that is wrong shows at once in the readback of the next write, and as a rate error in the run that follows. A synchroniser or edge-select fault shifts tb_b by a few cycles or by half the event count, so tb_b is compared only after the pin has settled.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int CFG_W = 16;
    localparam int DIV_W = 3;

    typedef struct packed {
        logic       edge_both;
        logic       compat;
        logic       pre_fast;
        logic       wr_ovr;
        logic       gate_mode;
        logic       emu;
        logic [1:0] psc_b;
        logic [1:0] psc_a;
        logic       stop;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        edge_both: 1'b0, compat: 1'b1, pre_fast: 1'b0, wr_ovr: 1'b0,
        gate_mode: 1'b0, emu: 1'b0, psc_b: 2'b00, psc_a: 2'b00, stop: 1'b0
    };

    function automatic logic [CFG_W-1:0] cfg_pack(input cfg_t c, input logic flag);
        return {4'b0000, c.edge_both, c.compat, c.pre_fast, c.wr_ovr,
                flag, c.gate_mode, c.emu, c.psc_b, c.psc_a, c.stop};
    endfunction

    function automatic cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
        cfg_t c;
        c.stop      = w[0];
        c.psc_a     = w[2:1];
        c.psc_b     = w[4:3];
        c.emu       = w[5];
        c.gate_mode = w[6];
        c.wr_ovr    = w[8];
        c.pre_fast  = w[9];
        c.compat    = w[10];
        c.edge_both = w[11];
        return c;
    endfunction

    // low bits that must all be set in the phase count before a tick passes
    function automatic logic [DIV_W-1:0] div_mask(input logic [1:0] code);
        case (code)
            2'b00:   return 3'b000;
            2'b01:   return 3'b001;
            2'b10:   return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/tbase_cfg_reg.sv
module tbase_cfg_reg
    import tbase_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  cfg_t             wr_cfg,
    output cfg_t             cfg,
    output logic [CFG_W-1:0] rd_data
);
    localparam int ONCE_N = 4;
    localparam int O_PSCA = 0;
    localparam int O_PSCB = 1;
    localparam int O_EMU  = 2;
    localparam int O_CMP  = 3;

    cfg_t              cfg_q, cfg_d;
    logic [ONCE_N-1:0] once_q;
    logic              flag_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.stop      = wr_cfg.stop;
            cfg_d.gate_mode = wr_cfg.gate_mode;
            cfg_d.wr_ovr    = wr_cfg.wr_ovr;
            cfg_d.pre_fast  = wr_cfg.pre_fast;
            cfg_d.edge_both = wr_cfg.edge_both;
            if (!once_q[O_PSCA] || cfg_q.wr_ovr) cfg_d.psc_a = wr_cfg.psc_a;
            if (!once_q[O_PSCB] || cfg_q.wr_ovr) cfg_d.psc_b = wr_cfg.psc_b;
            if (!once_q[O_EMU])                  cfg_d.emu   = wr_cfg.emu;
            if (!once_q[O_CMP])                  cfg_d.compat = wr_cfg.compat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            once_q <= '0;
            flag_q <= 1'b0;
        end else begin
            cfg_q  <= cfg_d;
            flag_q <= cfg_q.stop;
            if (wr_en) once_q <= '1;
        end
    end

    assign cfg     = cfg_q;
    assign rd_data = cfg_pack(cfg_q, flag_q);
endmodule

// File: rtl/tbase_divstage.sv
module tbase_divstage
    import tbase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       step,
    input  logic [1:0] code,
    output logic       tick
);
    logic [DIV_W-1:0] ph_q;
    logic [DIV_W-1:0] mask;

    assign mask = div_mask(code);
    assign tick = step && ((ph_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr)  ph_q <= '0;
        else if (step)   ph_q <= ph_q + 1'b1;
    end
endmodule

// File: rtl/tbase_chan_a.sv
module tbase_chan_a #(
    parameter int CNT_W    = 16,
    parameter int PRE_SLOW = 32,
    parameter int PRE_FAST = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pre_fast,
    input  logic [1:0]       code,
    output logic [CNT_W-1:0] count
);
    localparam int PW = $clog2(PRE_SLOW);

    logic [PW-1:0]    pre_q;
    logic [PW-1:0]    pre_last;
    logic             pre_tick;
    logic             div_tick;
    logic [CNT_W-1:0] cnt_q;

    assign pre_last = pre_fast ? PW'(PRE_FAST - 1) : PW'(PRE_SLOW - 1);
    assign pre_tick = run && (pre_q == pre_last);

    always_ff @(posedge clk) begin
        if (rst || !run) pre_q <= '0;
        else if (pre_tick) pre_q <= '0;
        else pre_q <= pre_q + 1'b1;
    end

    tbase_divstage u_div (
        .clk (clk),
        .rst (rst),
        .clr (!run),
        .step(pre_tick),
        .code(code),
        .tick(div_tick)
    );

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= '0;
        else if (div_tick) cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;
endmodule

// File: rtl/tbase_chan_b.sv
module tbase_chan_b #(
    parameter int CNT_W    = 16,
    parameter int GATE_DIV = 8,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             gate_mode,
    input  logic             edge_both,
    input  logic [1:0]       code,
    input  logic             pin,
    output logic [CNT_W-1:0] count
);
    localparam int GW = $clog2(GATE_DIV);

    logic [SYNC_N:0]  sh_q;
    logic             pin_s, pin_prev;
    logic [GW-1:0]    gdiv_q;
    logic             gate_tick, edge_ev, src_ev, div_tick;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SYNC_N-1:0], pin};
    end
    assign pin_s    = sh_q[SYNC_N-1];
    assign pin_prev = sh_q[SYNC_N];

    always_ff @(posedge clk) begin
        if (rst || !run) gdiv_q <= '0;
        else if (gdiv_q == GW'(GATE_DIV - 1)) gdiv_q <= '0;
        else gdiv_q <= gdiv_q + 1'b1;
    end

    assign gate_tick = (gdiv_q == GW'(GATE_DIV - 1)) && pin_s;
    assign edge_ev   = edge_both ? (pin_s ^ pin_prev) : (pin_s & ~pin_prev);
    assign src_ev    = run && (gate_mode ? gate_tick : edge_ev);

    tbase_divstage u_div (
        .clk (clk),
        .rst (rst),
        .clr (!run),
        .step(src_ev),
        .code(code),
        .tick(div_tick)
    );

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= '0;
        else if (div_tick) cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;
endmodule

// File: rtl/tbase_pair.sv
module tbase_pair
    import tbase_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PRE_SLOW = 32,
    parameter int PRE_FAST = 4,
    parameter int GATE_DIV = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [15:0]      cfg_wdata,
    output logic [15:0]      cfg_rdata,
    input  logic             ext_pin,
    output logic [CNT_W-1:0] tb_a,
    output logic [CNT_W-1:0] tb_b
);
    cfg_t cfg;
    cfg_t wr_cfg;
    logic run;

    assign wr_cfg = cfg_unpack(cfg_wdata);
    assign run    = !cfg.stop;

    tbase_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_cfg (wr_cfg),
        .cfg    (cfg),
        .rd_data(cfg_rdata)
    );

    tbase_chan_a #(
        .CNT_W(CNT_W), .PRE_SLOW(PRE_SLOW), .PRE_FAST(PRE_FAST)
    ) u_a (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .pre_fast(cfg.pre_fast),
        .code    (cfg.psc_a),
        .count   (tb_a)
    );

    tbase_chan_b #(
        .CNT_W(CNT_W), .GATE_DIV(GATE_DIV)
    ) u_b (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .gate_mode(cfg.gate_mode),
        .edge_both(cfg.edge_both),
        .code     (cfg.psc_b),
        .pin      (ext_pin),
        .count    (tb_b)
    );
endmodule

// File: rtl/tbase_pair_chk.sv
module tbase_pair_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [15:0]      cfg_rdata,
    input logic [CNT_W-1:0] tb_a,
    input logic [CNT_W-1:0] tb_b
);
    a_r2_a_single_step: assert property (@(posedge clk) disable iff (rst)
        (tb_a != $past(tb_a)) |-> (tb_a == $past(tb_a) + 1'b1));

    a_r3_a_min_gap: assert property (@(posedge clk) disable iff (rst)
        (tb_a != $past(tb_a)) |-> ($past(tb_a) == $past(tb_a, 2)));

    a_r9_b_single_step: assert property (@(posedge clk) disable iff (rst)
        (tb_b != $past(tb_b)) |-> (tb_b == $past(tb_b) + 1'b1));

    a_r4_frozen: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_rdata[0]) |-> ($stable(tb_a) && $stable(tb_b)));

    a_r5_flag_follows: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[7] == $past(cfg_rdata[0]));

    a_r12_no_write_no_change: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_we) |-> (cfg_rdata[15:8] == $past(cfg_rdata[15:8]) &&
                            cfg_rdata[6:0] == $past(cfg_rdata[6:0])));
endmodule

bind tbase_pair tbase_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_rdata(cfg_rdata),
    .tb_a     (tb_a),
    .tb_b     (tb_b)
);

// File: tb/tbase_pair_bench.sv
module tbase_pair_bench;
    localparam int CW = 8;
    localparam int MOD = 1 << CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic          ext_pin = 1'b0;
    logic [CW-1:0] tb_a, tb_b;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    tbase_pair #(.CNT_W(CW)) u_tbase_pair (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ext_pin(ext_pin), .tb_a(tb_a), .tb_b(tb_b)
    );

    function automatic logic [15:0] mk(input bit stp, input int pa, input int pb,
                                       input bit emu, input bit gate, input bit ovr,
                                       input bit sel, input bit cmp, input bit edg);
        logic [15:0] w = '0;
        w[0] = stp; w[2:1] = pa[1:0]; w[4:3] = pb[1:0]; w[5] = emu;
        w[6] = gate; w[8] = ovr; w[9] = sel; w[10] = cmp; w[11] = edg;
        return w;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic run_cycles(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int base, hold, hold_b, p;

        // R1: reset values
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 rdata", int'(cfg_rdata), 16'h0400);
        chk("R1 tb_a", int'(tb_a), 0);
        chk("R1 tb_b", int'(tb_b), 0);
        rst = 1'b0;

        // R2 R3 R11: timebase A rate over every pre-divider and divider code
        for (int sel = 0; sel < 2; sel++) begin
            for (int pa = 0; pa < 4; pa++) begin
                do_reset();
                wr(mk(1, pa, 0, 0, 0, 0, sel[0], 1, 0));
                base = int'(tb_a);
                wr(mk(0, pa, 0, 0, 0, 0, sel[0], 1, 0));
                run_cycles(3000);
                p = (sel == 1 ? 4 : 32) << pa;
                chk("R2 R3 R11 tb_a rate", int'(tb_a), (base + 3000 / p) % MOD);
            end
        end

        // R4 R5: stop freezes, flag lags, resume restarts phase
        do_reset();
        wr(mk(0, 2, 0, 0, 0, 0, 1, 1, 0));
        run_cycles(300);
        wr(mk(1, 2, 0, 0, 0, 0, 1, 1, 0));
        chk("R5 stop bit", int'(cfg_rdata[0]), 1);
        chk("R5 flag lag", int'(cfg_rdata[7]), 0);
        hold = int'(tb_a); hold_b = int'(tb_b);
        run_cycles(1);
        chk("R5 flag set", int'(cfg_rdata[7]), 1);
        run_cycles(100);
        chk("R4 tb_a held", int'(tb_a), hold);
        chk("R4 tb_b held", int'(tb_b), hold_b);
        wr(mk(0, 2, 0, 0, 0, 0, 1, 1, 0) | 16'h0080);
        chk("R5 flag after clear", int'(cfg_rdata[7]), 1);
        run_cycles(1);
        chk("R5 flag cleared", int'(cfg_rdata[7]), 0);
        run_cycles(159);
        chk("R4 resume", int'(tb_a), (hold + 160 / 16) % MOD);

        // R6 R7: write-once divider fields and override
        do_reset();
        wr(mk(1, 1, 2, 0, 0, 0, 1, 1, 0));
        wr(mk(1, 3, 0, 0, 0, 0, 1, 1, 0));
        chk("R6 psc_a kept", int'(cfg_rdata[2:1]), 1);
        chk("R6 psc_b kept", int'(cfg_rdata[4:3]), 2);
        base = int'(tb_a);
        wr(mk(0, 3, 0, 0, 0, 0, 1, 1, 0));
        run_cycles(400);
        chk("R6 rate unchanged", int'(tb_a), (base + 400 / 8) % MOD);
        wr(mk(1, 3, 0, 0, 0, 1, 1, 1, 0));
        chk("R6 ovr not yet stored", int'(cfg_rdata[2:1]), 1);
        wr(mk(1, 3, 1, 0, 0, 1, 1, 1, 0));
        chk("R7 psc_a override", int'(cfg_rdata[2:1]), 3);
        chk("R7 psc_b override", int'(cfg_rdata[4:3]), 1);
        base = int'(tb_a);
        wr(mk(0, 3, 1, 0, 0, 1, 1, 1, 0));
        run_cycles(400);
        chk("R7 rate new", int'(tb_a), (base + 400 / 32) % MOD);

        // R8 R12: once-only mode bits, reserved bits, plain readback
        do_reset();
        wr(mk(1, 0, 0, 1, 1, 1, 1, 0, 1) | 16'hF000);
        chk("R8 R12 first write", int'(cfg_rdata), int'(mk(1, 0, 0, 1, 1, 1, 1, 0, 1)));
        wr(mk(0, 0, 0, 0, 0, 0, 0, 1, 0) | 16'hF000);
        chk("R8 R12 second write", int'(cfg_rdata),
            int'(mk(0, 0, 0, 1, 0, 0, 0, 0, 0) | 16'h0080));

        // R9: pin edge counting, rising and both edges
        for (int edg = 0; edg < 2; edg++) begin
            for (int pb = 0; pb < 4; pb++) begin
                ext_pin = 1'b0;
                do_reset();
                wr(mk(1, 0, pb, 0, 0, 0, 0, 1, edg[0]));
                run_cycles(4);
                base = int'(tb_b);
                wr(mk(0, 0, pb, 0, 0, 0, 0, 1, edg[0]));
                for (int i = 0; i < 37; i++) begin
                    ext_pin = 1'b1; repeat (3) @(negedge clk);
                    ext_pin = 1'b0; repeat (3) @(negedge clk);
                end
                run_cycles(6);
                chk("R9 edge count", int'(tb_b),
                    (base + ((37 * (edg + 1)) >> pb)) % MOD);
            end
        end

        // R10 R11: gated internal clock
        for (int pb = 0; pb < 4; pb++) begin
            ext_pin = 1'b1;
            do_reset();
            wr(mk(1, 0, pb, 0, 1, 0, 0, 1, 0));
            run_cycles(4);
            base = int'(tb_b);
            wr(mk(0, 0, pb, 0, 1, 0, 0, 1, 0));
            run_cycles(2400);
            chk("R10 R11 gated count", int'(tb_b), (base + ((2400 / 8) >> pb)) % MOD);
            ext_pin = 1'b0;
            run_cycles(4);
            hold_b = int'(tb_b);
            run_cycles(200);
            chk("R10 gate low", int'(tb_b), hold_b);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule